// File: doc/BRIEF.md
# NAND ECC Syndrome Checker and Corrector

This block takes the 22-bit ECC code read back from flash next to a 256-byte data chunk, together with the code freshly computed over the data as it was read, and decides what went wrong, if anything. The XOR of the two codes (the syndrome) is classified into one of four outcomes. The data was clean. The stored code itself took a hit and the data is good. A single data bit flipped and can be repaired. The damage is beyond repair. For a repairable flip the block gives the byte offset within the page and a one-hot mask of the bad bit. The host, or a port into the page buffer, XORs that mask into the byte. The block never touches the data buffer.

For 512-byte pages each code input carries two 22-bit codes, one for each half of the page. After a single start the block checks the lower half and then the upper half on consecutive cycles. Each half gets its own result, and the result for the upper half carries byte offsets of 256 and above. A running page status ORs the two half results together. The syndrome popcount goes through a registered adder tree, so each half's result appears two cycles after that half enters the pipeline.

Top module: `nand_ecc_syndrome`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `done`, `status`, `byte_idx`, `bit_mask`, `last_chunk` and `total_status` are all zero.
- R2: Take `start` high in cycle n with `wide_mode` low. Then `done` is high in cycle n+2 only, with `last_chunk` high. With `wide_mode` high, `done` is high in cycles n+2 (lower half, `last_chunk` low) and n+3 (upper half, `last_chunk` high). In every cycle where `done` is low, all other outputs are zero.
- R3: If the syndrome (calculated XOR stored) is zero, or either code is all zeros, `status` is 0 (clean). `byte_idx` and `bit_mask` are then zero.
- R4: If the syndrome has exactly one bit set and neither code is zero, `status` is 2 (the error is in the stored code only). `byte_idx` and `bit_mask` are zero.
- R5: Suppose the syndrome has exactly 11 bits set and each bit j differs from bit j+11 for j = 0..10. Neither code may be zero. Then `status` is 1 (repairable). `bit_mask` is 1 shifted left by syndrome bits [2:0], and `byte_idx` is syndrome bits [10:3], plus 256 for the upper half.
- R6: Every syndrome not covered by R3, R4 or R5 gives `status` 3 (not repairable), with `byte_idx` and `bit_mask` zero.
- R7: The lower half uses code bits [21:0] and the upper half uses bits [43:22]. When `wide_mode` is low, bits [43:22] are ignored. `total_status` equals `status` on a lower-half or single-half result. On the upper-half result it equals the bitwise OR of the two half statuses.
- R8: A `start` in the cycle right after a start taken with `wide_mode` high is ignored. No third result follows, and the two results reflect the codes sampled with the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Samples the codes and begins a check |
| wide_mode | input | 1 | 1: two halves (512-byte page), 0: one 256-byte chunk |
| calc_code | input | 44 | Calculated codes, lower half in [21:0], upper in [43:22] |
| stored_code | input | 44 | Codes read from flash, same layout |
| done | output | 1 | One half's result is valid this cycle |
| status | output | 2 | 0 clean, 1 repaired bit, 2 code-only error, 3 not repairable |
| byte_idx | output | 9 | Page byte offset of the bad bit (valid for status 1) |
| bit_mask | output | 8 | One-hot mask of the bad bit (valid for status 1) |
| last_chunk | output | 1 | This result is the final half of the check |
| total_status | output | 2 | OR of the half statuses so far in this check |

## Verification
With start in cycle n, the single or lower-half result is due in cycle n+2: one register stage holds the syndrome and partial counts, and a second holds the verdict. The upper-half result follows in cycle n+3. The bench drives inputs at the falling edge. It then samples outputs at the falling edge of cycle n+1 to confirm nothing is out early, at n+2 and, in wide mode, n+3 for the results, and one cycle later to confirm the outputs have returned to zero. The expected class is computed from the syndrome popcount and the pair-difference rule. The sweep covers every one of the 2048 repairable bit positions, every single-bit syndrome, the zero-code cases, and all sixteen pairings of half outcomes in wide mode.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    // Width of one chunk's code; halves hold the line parity and its complement
    localparam int CODE_W = 22;
    localparam int HALF_W = CODE_W / 2;
    localparam int BIT_W  = 3;
    localparam int BYTE_W = HALF_W - BIT_W;
    localparam int IDX_W  = BYTE_W + 1;
    localparam int MASK_W = 1 << BIT_W;
    localparam int CNT_W  = $clog2(CODE_W + 1);
    localparam int WIDE_W = 2 * CODE_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_CODE  = 2'd2,
        ST_BAD   = 2'd3
    } ecc_status_e;

    // Pipeline stage 1 contents
    typedef struct packed {
        logic              valid;
        logic              chunk;
        logic              last;
        logic              trivial;
        logic [HALF_W-1:0] syn_lo;
        logic [HALF_W-1:0] pairx;
    } stage1_t;

    typedef struct packed {
        ecc_status_e       status;
        logic [IDX_W-1:0]  idx;
        logic [MASK_W-1:0] mask;
    } verdict_t;

    function automatic logic [MASK_W-1:0] bit_onehot(input logic [BIT_W-1:0] b);
        return MASK_W'(1) << b;
    endfunction
endpackage

// File: rtl/nsc_popcnt.sv
module nsc_popcnt #(
    parameter int W     = 22,
    parameter int GRP_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [W-1:0]           vec,
    output logic [$clog2(W+1)-1:0] count
);
    localparam int NGRP = (W + GRP_W - 1) / GRP_W;
    localparam int PADW = NGRP * GRP_W;
    localparam int PW   = $clog2(GRP_W + 1);
    localparam int CW   = $clog2(W + 1);

    logic [PADW-1:0] padded;
    logic [PW-1:0]   part_d [NGRP];
    logic [PW-1:0]   part_q [NGRP];

    assign padded = PADW'(vec);

    // First level of the tree: per-group counts, registered
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            part_d[g] = '0;
            for (int j = 0; j < GRP_W; j++) begin
                part_d[g] = part_d[g] + PW'(padded[g*GRP_W + j]);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < NGRP; g++) begin
            if (rst) part_q[g] <= '0;
            else     part_q[g] <= part_d[g];
        end
    end

    // Second level: sum of group counts
    always_comb begin
        count = '0;
        for (int g = 0; g < NGRP; g++) begin
            count = count + CW'(part_q[g]);
        end
    end
endmodule

// File: rtl/nsc_front.sv
module nsc_front
    import nsc_pkg::*;
#(
    parameter int GRP_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid,
    input  logic                chunk,
    input  logic                last,
    input  logic [CODE_W-1:0]   calc,
    input  logic [CODE_W-1:0]   stored,
    output stage1_t             s1,
    output logic [CNT_W-1:0]    count
);
    logic [CODE_W-1:0] syn_d;
    stage1_t           s1_d;

    assign syn_d = calc ^ stored;

    always_comb begin
        s1_d.valid   = valid;
        s1_d.chunk   = chunk;
        s1_d.last    = last;
        s1_d.trivial = (syn_d == '0) || (calc == '0) || (stored == '0);
        s1_d.syn_lo  = syn_d[HALF_W-1:0];
        s1_d.pairx   = syn_d[HALF_W-1:0] ^ syn_d[CODE_W-1:HALF_W];
    end

    always_ff @(posedge clk) begin
        if (rst) s1 <= '0;
        else     s1 <= s1_d;
    end

    nsc_popcnt #(.W(CODE_W), .GRP_W(GRP_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .vec   (syn_d),
        .count (count)
    );
endmodule

// File: rtl/nsc_judge.sv
module nsc_judge
    import nsc_pkg::*;
(
    input  logic              trivial,
    input  logic              chunk,
    input  logic [HALF_W-1:0] syn_lo,
    input  logic [HALF_W-1:0] pairx,
    input  logic [CNT_W-1:0]  count,
    output verdict_t          verdict
);
    logic pairs_split;
    assign pairs_split = &pairx;

    always_comb begin
        verdict = '0;
        if (trivial) begin
            verdict.status = ST_CLEAN;
        end else if (count == CNT_W'(1)) begin
            verdict.status = ST_CODE;
        end else if (count == CNT_W'(HALF_W) && pairs_split) begin
            verdict.status = ST_FIXED;
            verdict.idx    = {chunk, syn_lo[HALF_W-1:BIT_W]};
            verdict.mask   = bit_onehot(syn_lo[BIT_W-1:0]);
        end else begin
            verdict.status = ST_BAD;
        end
    end
endmodule

// File: rtl/nand_ecc_syndrome.sv
module nand_ecc_syndrome
    import nsc_pkg::*;
#(
    parameter int GRP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wide_mode,
    input  logic [WIDE_W-1:0] calc_code,
    input  logic [WIDE_W-1:0] stored_code,
    output logic              done,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [MASK_W-1:0] bit_mask,
    output logic              last_chunk,
    output logic [1:0]        total_status
);
    logic              pend_q;
    logic [CODE_W-1:0] hi_calc_q, hi_stored_q;
    logic              take;
    logic              feed_valid, feed_chunk, feed_last;
    logic [CODE_W-1:0] feed_calc, feed_stored;
    stage1_t           s1;
    logic [CNT_W-1:0]  count;
    verdict_t          verdict;

    // Sequencer: a wide check issues the upper half one cycle after the lower
    assign take = start && !pend_q;

    always_comb begin
        if (pend_q) begin
            feed_valid  = 1'b1;
            feed_chunk  = 1'b1;
            feed_last   = 1'b1;
            feed_calc   = hi_calc_q;
            feed_stored = hi_stored_q;
        end else begin
            feed_valid  = take;
            feed_chunk  = 1'b0;
            feed_last   = !wide_mode;
            feed_calc   = calc_code[CODE_W-1:0];
            feed_stored = stored_code[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            hi_calc_q   <= '0;
            hi_stored_q <= '0;
        end else begin
            pend_q <= take && wide_mode;
            if (take && wide_mode) begin
                hi_calc_q   <= calc_code[WIDE_W-1:CODE_W];
                hi_stored_q <= stored_code[WIDE_W-1:CODE_W];
            end
        end
    end

    nsc_front #(.GRP_W(GRP_W)) u_front (
        .clk    (clk),
        .rst    (rst),
        .valid  (feed_valid),
        .chunk  (feed_chunk),
        .last   (feed_last),
        .calc   (feed_calc),
        .stored (feed_stored),
        .s1     (s1),
        .count  (count)
    );

    nsc_judge u_judge (
        .trivial (s1.trivial),
        .chunk   (s1.chunk),
        .syn_lo  (s1.syn_lo),
        .pairx   (s1.pairx),
        .count   (count),
        .verdict (verdict)
    );

    // Result register
    always_ff @(posedge clk) begin
        if (rst || !s1.valid) begin
            done         <= 1'b0;
            status       <= '0;
            byte_idx     <= '0;
            bit_mask     <= '0;
            last_chunk   <= 1'b0;
            total_status <= '0;
        end else begin
            done         <= 1'b1;
            status       <= verdict.status;
            byte_idx     <= verdict.idx;
            bit_mask     <= verdict.mask;
            last_chunk   <= s1.last;
            total_status <= s1.chunk ? (total_status | verdict.status) : verdict.status;
        end
    end
endmodule

// File: rtl/nand_ecc_syndrome_chk.sv
module nand_ecc_syndrome_chk
    import nsc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              wide_mode,
    input logic              done,
    input logic [1:0]        status,
    input logic [IDX_W-1:0]  byte_idx,
    input logic [MASK_W-1:0] bit_mask,
    input logic              last_chunk,
    input logic [1:0]        total_status
);
    // R2
    start_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !$past(start && wide_mode)) |-> ##2 done);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> (status == 2'd0 && byte_idx == '0 && bit_mask == '0 &&
                   !last_chunk && total_status == 2'd0));

    // R5
    fix_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'd1) |-> $countones(bit_mask) == 1);

    // R6
    nofix_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && status != 2'd1) |-> (bit_mask == '0 && byte_idx == '0));

    // R7
    half_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !last_chunk) |=> (done && last_chunk));

    // R7
    first_total_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !last_chunk) |-> total_status == status);

    // R7
    page_total_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !last_chunk) |=> total_status == ($past(status) | status));

    // R5
    upper_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !last_chunk) |=> (status != 2'd1 || byte_idx[IDX_W-1]));
endmodule

bind nand_ecc_syndrome nand_ecc_syndrome_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .wide_mode    (wide_mode),
    .done         (done),
    .status       (status),
    .byte_idx     (byte_idx),
    .bit_mask     (bit_mask),
    .last_chunk   (last_chunk),
    .total_status (total_status)
);

// File: tb/nand_ecc_syndrome_test.sv
module nand_ecc_syndrome_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [43:0] calc_code = '0;
    logic [43:0] stored_code = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  byte_idx;
    logic [7:0]  bit_mask;
    logic        last_chunk;
    logic [1:0]  total_status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nand_ecc_syndrome uut (
        .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode),
        .calc_code(calc_code), .stored_code(stored_code),
        .done(done), .status(status), .byte_idx(byte_idx), .bit_mask(bit_mask),
        .last_chunk(last_chunk), .total_status(total_status)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference classification from the requirement text
    task automatic model(input logic [21:0] c, input logic [21:0] s,
                         output int st, output int by, output int mk);
        logic [21:0] syn;
        int cnt;
        bit split;
        syn = c ^ s;
        cnt = 0;
        for (int i = 0; i < 22; i++) cnt += int'(syn[i]);
        split = 1'b1;
        for (int j = 0; j < 11; j++) if (syn[j] == syn[j+11]) split = 1'b0;
        by = 0;
        mk = 0;
        if (syn == 0 || c == 0 || s == 0) st = 0;
        else if (cnt == 1) st = 2;
        else if (cnt == 11 && split) begin
            st = 1;
            by = int'(syn[10:3]);
            mk = 1 << syn[2:0];
        end else st = 3;
    endtask

    task automatic expect_res(input string req, input int st, input int by, input int mk,
                              input bit last, input int tot);
        chk("R2", "done", int'(done), 1);
        chk(req, "status", int'(status), st);
        chk(req, "byte_idx", int'(byte_idx), by);
        chk(req, "bit_mask", int'(bit_mask), mk);
        chk("R2", "last_chunk", int'(last_chunk), int'(last));
        chk("R7", "total_status", int'(total_status), tot);
    endtask

    task automatic expect_idle(input string req);
        chk(req, "idle done", int'(done), 0);
        chk(req, "idle status", int'(status), 0);
        chk(req, "idle total", int'(total_status), 0);
    endtask

    task automatic run(input string req, input bit wide, input logic [43:0] c, input logic [43:0] s);
        int st0, by0, mk0, st1, by1, mk1;
        model(c[21:0], s[21:0], st0, by0, mk0);
        model(c[43:22], s[43:22], st1, by1, mk1);
        @(negedge clk);
        wide_mode = wide;
        calc_code = c;
        stored_code = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        calc_code = ~c;
        stored_code = s ^ 44'h5;
        chk("R2", "early done", int'(done), 0);
        @(negedge clk);
        expect_res(req, st0, by0, mk0, !wide, st0);
        if (wide) begin
            @(negedge clk);
            expect_res(req, st1, (st1 == 1) ? by1 + 256 : 0, mk1, 1'b1, st0 | st1);
        end
        @(negedge clk);
        expect_idle("R2");
    endtask

    // Builds a code pair of a chosen class
    function automatic logic [21:0] syn_of(input int k, input int n);
        logic [10:0] a;
        a = 11'(n);
        case (k)
            0: return 22'h0;
            1: return {~a, a};
            2: return 22'(1) << (n % 22);
            default: return 22'h3 << (n % 20);
        endcase
    endfunction

    localparam logic [21:0] BASE = 22'h2B4C3;

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_idle("R1");
        chk("R1", "reset mask", int'(bit_mask), 0);
        chk("R1", "reset idx", int'(byte_idx), 0);
        chk("R1", "reset last", int'(last_chunk), 0);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1");

        // R5: every repairable position, single-chunk mode, garbage upper bits (R7)
        for (int n = 0; n < 2048; n++) begin
            logic [21:0] s;
            logic [10:0] a;
            a = 11'(n);
            s = {11'(n * 37 + 5), a ^ 11'h001};
            run("R5", 1'b0, {22'(n * 977 + 3), s ^ {~a, a}}, {22'(n * 313), s});
        end

        // R4: every single-bit syndrome
        for (int b = 0; b < 22; b++) begin
            run("R4", 1'b0, {22'h0, BASE ^ (22'(1) << b)}, {22'h1, BASE});
        end

        // R3: zero syndrome and zero codes
        run("R3", 1'b0, {22'h0, BASE}, {22'h0, BASE});
        run("R3", 1'b0, {22'h0, BASE}, {22'h0, 22'h0});
        run("R3", 1'b0, {22'h0, 22'h0}, {22'h0, 22'h3FFFFF});
        run("R3", 1'b0, {22'h0, 22'h0}, {22'h0, 22'h0});

        // R6: multi-bit syndromes
        for (int b = 0; b < 21; b++) begin
            run("R6", 1'b0, {22'h0, BASE ^ (22'h3 << b)}, {22'h0, BASE});
        end
        run("R6", 1'b0, {22'h0, ~BASE}, {22'h0, BASE});
        run("R6", 1'b0, {22'h0, BASE ^ 22'h0013FF}, {22'h0, BASE});
        // R5: low half all ones is a legal repair of byte 255 bit 7
        run("R5", 1'b0, {22'h0, BASE ^ 22'h0007FF}, {22'h0, BASE});

        // R7: all pairings of half outcomes in wide mode
        for (int k0 = 0; k0 < 4; k0++) begin
            for (int k1 = 0; k1 < 4; k1++) begin
                logic [21:0] s0, s1;
                s0 = BASE;
                s1 = BASE ^ 22'h15A5A;
                run("R7", 1'b1,
                    {s1 ^ syn_of(k1, 100 + k0 * 7 + k1), s0 ^ syn_of(k0, 1500 + k1 * 11)},
                    {s1, s0});
            end
        end

        // R8: start held for a second cycle after a wide start is ignored
        begin
            logic [43:0] c, s;
            int st0, by0, mk0, st1, by1, mk1;
            s = {BASE ^ 22'h0F0F0, BASE};
            c = s ^ {syn_of(1, 300), syn_of(1, 42)};
            model(c[21:0], s[21:0], st0, by0, mk0);
            model(c[43:22], s[43:22], st1, by1, mk1);
            @(negedge clk);
            wide_mode = 1'b1;
            calc_code = c;
            stored_code = s;
            start = 1'b1;
            @(negedge clk);
            calc_code = {22'h0, BASE ^ 22'h1};
            stored_code = {22'h0, BASE};
            wide_mode = 1'b0;
            @(negedge clk);
            start = 1'b0;
            expect_res("R8", st0, by0, mk0, 1'b0, st0);
            @(negedge clk);
            expect_res("R8", st1, by1 + 256, mk1, 1'b1, st0 | st1);
            @(negedge clk);
            expect_idle("R8");
            @(negedge clk);
            expect_idle("R8");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule